// File: doc/BRIEF.md
# Passive Color Subpixel Packer

This block sits between the frame buffer and an 8-wire passive color panel. Pixels arrive one at a time through a valid/ready handshake, already past the palette, either as 12-bit 4-4-4 words or as 16-bit 5-6-5 words. The block cuts each pixel into red, green and blue 4-bit channels. It sends each channel through its own dither lane and gets one subpixel bit per channel. It then packs the subpixel bits onto the 8-wire bus, one bit per wire per word. A pulse on `sp_strobe` marks each new word, and the panel pixel clock is paired with that pulse.

Eight subpixels do not divide into whole pixels. A word therefore carries two and two-thirds pixels, and pixel edges move to a different wire in each of three consecutive words. After eight pixels the pattern repeats. A small ordering buffer holds the leftover subpixels from one word to the next. A line-start pulse sends any partial word out at once, so one line never shares a word with the next. In this block each dither lane is a pass-through stand-in, and panel timing is handled elsewhere.

The control is a two-state machine. `ST_RUN` emits a full word whenever eight or more subpixels are held, and otherwise accepts pixels. A `line_start` pulse moves it from `ST_RUN` to `ST_FLUSH`. `ST_FLUSH` emits the partial word, if there is one, clears the buffer and always returns to `ST_RUN` on the next cycle.

Top module: `subpix_packer`

## Requirements
- R1: After reset, `px_ready` is 1, and `sp_strobe` and `sp_word` are 0.
- R2: When `fmt_565` is 0, the pixel is 4-4-4 with red in bits [11:8], green in [7:4] and blue in [3:0]. Bits [15:12] have no effect.
- R3: When `fmt_565` is 1, the pixel is 5-6-5 and the channels are taken from red [15:12], green [10:7] and blue [4:1]. Bits 11, 6, 5 and 0 have no effect.
- R4: Each channel passes through its own dither lane. The lane produces a subpixel bit of 1 exactly when the 4-bit channel value is 8 or more.
- R5: Subpixels leave in order of acceptance: red, then green, then blue for each pixel. The earliest subpixel in a word is on `sp_word[0]` and the latest is on `sp_word[7]`.
- R6: A word is output only when it holds 8 subpixels. `sp_strobe` is high for that one cycle, two clock edges after the edge that accepted the pixel completing the word. Leftover subpixels start the next word, so eight pixels make exactly three words. `sp_word` is 0 whenever `sp_strobe` is low.
- R7: A pixel is taken only on an edge where both `px_valid` and `px_ready` are high. `px_ready` is low while 8 or more subpixels are held, during `line_start`, and in the cycle that follows `line_start`.
- R8: A `line_start` pulse sends the held subpixels as one word, with the unused upper wires at 0. With an empty buffer it produces no strobe. The next pixel starts at `sp_word[0]`, and `px_ready` is high again two cycles after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_565 | input | 1 | Input format: 1 selects 5-6-5, 0 selects 4-4-4 |
| line_start | input | 1 | Start-of-line pulse; flushes a partial word |
| px_valid | input | 1 | Pixel offered |
| px_data | input | 16 | Pixel value |
| px_ready | output | 1 | Pixel can be accepted this cycle |
| sp_word | output | 8 | Subpixel bits, one per panel wire |
| sp_strobe | output | 1 | New word on `sp_word` this cycle |

## Verification
A wrong subpixel count inside the buffer changes the cycles in which `px_ready` drops. It also shifts every later pixel edge across the wires, so the first or second word after the fault already differs from the bench's own packing model. Buffer bits that are not cleared show up as stray ones on the upper wires of the next flushed partial word. A wrong state after `line_start` shows up within two cycles: either `px_ready` stays high when it must be low, or a strobe appears with no accepted pixel or flush to explain it.

// File: rtl/subpix_pkg.sv
package subpix_pkg;

    // subpixels produced per pixel (red, green, blue)
    localparam int N_SUB = 3;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } pk_state_e;

endpackage

// File: rtl/subpix_split.sv
module subpix_split #(
    parameter int PX_W  = 16,
    parameter int CH_W  = 4,
    parameter int R_MSB = 15,
    parameter int G_MSB = 10,
    parameter int B_MSB = 4
) (
    input  logic                                       fmt_565,
    input  logic [PX_W-1:0]                            px,
    output logic [subpix_pkg::N_SUB-1:0][CH_W-1:0]     chan
);

    // channel 0 = red, 1 = green, 2 = blue
    for (genvar i = 0; i < subpix_pkg::N_SUB; i++) begin : g_ch
        localparam int NARROW_LSB = (subpix_pkg::N_SUB - 1 - i) * CH_W;
        localparam int WIDE_MSB   = (i == 0) ? R_MSB : ((i == 1) ? G_MSB : B_MSB);
        assign chan[i] = fmt_565 ? px[WIDE_MSB -: CH_W] : px[NARROW_LSB +: CH_W];
    end

endmodule

// File: rtl/subpix_lane.sv
module subpix_lane #(
    parameter int CH_W = 4
) (
    input  logic [CH_W-1:0] level,
    output logic            lit
);

    // pass-through stand-in for a dither lane: threshold at half scale
    localparam logic [CH_W-1:0] HALF = CH_W'(1) << (CH_W - 1);

    assign lit = (level >= HALF);

endmodule

// File: rtl/subpix_packer.sv
module subpix_packer #(
    parameter int PX_W  = 16,
    parameter int CH_W  = 4,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_565,
    input  logic             line_start,
    input  logic             px_valid,
    input  logic [PX_W-1:0]  px_data,
    output logic             px_ready,
    output logic [BUS_W-1:0] sp_word,
    output logic             sp_strobe
);
    import subpix_pkg::*;

    localparam int BUF_W = BUS_W + N_SUB - 1;
    localparam int CNT_W = $clog2(BUF_W + 1);

    logic [N_SUB-1:0][CH_W-1:0] chan;
    logic [N_SUB-1:0]           sub_bits;

    subpix_split #(.PX_W(PX_W), .CH_W(CH_W)) split_i (
        .fmt_565 (fmt_565),
        .px      (px_data),
        .chan    (chan)
    );

    for (genvar i = 0; i < N_SUB; i++) begin : g_lane
        subpix_lane #(.CH_W(CH_W)) lane_i (
            .level (chan[i]),
            .lit   (sub_bits[i])
        );
    end

    pk_state_e        state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [BUF_W-1:0] hold, hold_nxt;
    logic [BUS_W-1:0] word_nxt;
    logic             strobe_nxt;
    logic             full, take;

    assign full     = (cnt >= CNT_W'(BUS_W));
    assign px_ready = (state == ST_RUN) && !line_start && !full;
    assign take     = px_valid && px_ready;

    always_comb begin
        state_nxt  = state;
        cnt_nxt    = cnt;
        hold_nxt   = hold;
        word_nxt   = '0;
        strobe_nxt = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (full) begin
                    word_nxt   = hold[BUS_W-1:0];
                    strobe_nxt = 1'b1;
                    hold_nxt   = hold >> BUS_W;
                    cnt_nxt    = cnt - CNT_W'(BUS_W);
                end else if (take) begin
                    hold_nxt = hold | (BUF_W'(sub_bits) << cnt);
                    cnt_nxt  = cnt + CNT_W'(N_SUB);
                end
                if (line_start) begin
                    state_nxt = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (cnt != '0) begin
                    word_nxt   = hold[BUS_W-1:0];
                    strobe_nxt = 1'b1;
                end
                hold_nxt  = '0;
                cnt_nxt   = '0;
                state_nxt = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            cnt       <= '0;
            hold      <= '0;
            sp_word   <= '0;
            sp_strobe <= 1'b0;
        end else begin
            state     <= state_nxt;
            cnt       <= cnt_nxt;
            hold      <= hold_nxt;
            sp_word   <= word_nxt;
            sp_strobe <= strobe_nxt;
        end
    end

endmodule

// File: rtl/subpix_packer_chk.sv
module subpix_packer_chk #(
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_start,
    input logic             px_valid,
    input logic             px_ready,
    input logic [BUS_W-1:0] sp_word,
    input logic             sp_strobe
);

    AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sp_strobe |-> ($past(px_valid && px_ready, 2) || $past(line_start, 2))); // R6

    AST_IDLE_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_strobe |-> (sp_word == '0)); // R6

    AST_NO_READY_AFTER_SOL: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !px_ready); // R7

    AST_READY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(line_start, 2) && !$past(line_start) && !line_start) |-> px_ready); // R8

endmodule

bind subpix_packer subpix_packer_chk #(.BUS_W(BUS_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .px_valid   (px_valid),
    .px_ready   (px_ready),
    .sp_word    (sp_word),
    .sp_strobe  (sp_strobe)
);

// File: tb/subpix_packer_tb_top.sv
module subpix_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_565 = 1'b0;
    logic        line_start = 1'b0;
    logic        px_valid = 1'b0;
    logic [15:0] px_data = '0;
    logic        px_ready;
    logic [7:0]  sp_word;
    logic        sp_strobe;

    always #5 clk = ~clk;

    subpix_packer dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_565(fmt_565), .line_start(line_start),
        .px_valid(px_valid), .px_data(px_data), .px_ready(px_ready),
        .sp_word(sp_word), .sp_strobe(sp_strobe)
    );

    int checks = 0;
    int errors = 0;

    // captured words (monitor only appends)
    logic [7:0] got_w [0:255];
    int         n_got = 0;
    always @(negedge clk) begin
        if (rst_n && sp_strobe && n_got < 256) begin
            got_w[n_got] = sp_word;
            n_got = n_got + 1;
        end
    end

    // bench packing model
    logic [7:0] exp_w [0:255];
    int         n_exp = 0;
    int         base_got = 0;
    int         base_exp = 0;
    logic [7:0] acc = '0;
    int         acc_n = 0;

    // {fmt_565, pixel}
    localparam int NV = 16;
    localparam logic [16:0] VEC [NV] = '{
        17'h00888, 17'h00800, 17'h00080, 17'h00008,
        17'h00F00, 17'h00777, 17'h0F088, 17'h00C4A,
        17'h18410, 17'h18000, 17'h10400, 17'h10010,
        17'h1FFFF, 17'h17BEF, 17'h10861, 17'h18001
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_bit(input logic b);
        acc[acc_n] = b;
        acc_n++;
        if (acc_n == 8) begin
            exp_w[n_exp] = acc;
            n_exp++;
            acc = '0;
            acc_n = 0;
        end
    endtask

    task automatic model_px(input logic f, input logic [15:0] d);
        if (f) begin
            model_bit(d[15]); model_bit(d[10]); model_bit(d[4]);
        end else begin
            model_bit(d[11]); model_bit(d[7]); model_bit(d[3]);
        end
    endtask

    task automatic model_flush();
        if (acc_n > 0) begin
            exp_w[n_exp] = acc;
            n_exp++;
        end
        acc = '0;
        acc_n = 0;
    endtask

    task automatic send_px(input logic f, input logic [15:0] d);
        @(negedge clk);
        fmt_565 = f; px_data = d; px_valid = 1'b1;
        #1;
        while (!px_ready) begin
            @(negedge clk);
            #1;
        end
        model_px(f, d);
    endtask

    task automatic line_break();
        @(negedge clk);
        px_valid = 1'b0;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        model_flush();
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(input string req);
        check((n_got - base_got) == (n_exp - base_exp), {req, " word count"},
              n_got - base_got, n_exp - base_exp);
        for (int i = 0; i < n_exp - base_exp && base_got + i < n_got; i++)
            check(got_w[base_got + i] == exp_w[base_exp + i], {req, " word"},
                  got_w[base_got + i], exp_w[base_exp + i]);
        base_got = n_got;
        base_exp = n_exp;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(px_ready == 1'b1, "R1 px_ready", px_ready, 1);
        check(sp_strobe == 1'b0, "R1 sp_strobe", sp_strobe, 0);
        check(sp_word == 8'h00, "R1 sp_word", sp_word, 0);

        // table walk: both formats, R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++)
            send_px(VEC[v][16], VEC[v][15:0]);
        @(negedge clk);
        px_valid = 1'b0;
        repeat (4) @(negedge clk);
        compare("R5/R6 table walk");
        line_break();
        compare("R8 empty flush after table");

        // R6/R7: cycle-exact ready drop and strobe timing
        send_px(1'b0, 16'h0888);
        send_px(1'b0, 16'h0888);
        send_px(1'b0, 16'h0008);
        @(negedge clk);
        px_valid = 1'b0;
        #1;
        check(px_ready == 1'b0, "R7 ready low with 9 held", px_ready, 0);
        check(sp_strobe == 1'b0, "R6 strobe not yet", sp_strobe, 0);
        @(negedge clk);
        #1;
        check(sp_strobe == 1'b1, "R6 strobe two edges after accept", sp_strobe, 1);
        check(sp_word == 8'h3F, "R5 word order", sp_word, 8'h3F);
        check(px_ready == 1'b1, "R7 ready back after emit", px_ready, 1);
        @(negedge clk);
        #1;
        check(sp_strobe == 1'b0, "R6 strobe one cycle", sp_strobe, 0);
        line_break();
        compare("R8 flush of leftover blue");

        // R8: partial word, zero tail, next line starts at wire 0
        send_px(1'b0, 16'h0888);
        send_px(1'b0, 16'h0888);
        line_break();
        compare("R8 partial word");
        check(got_w[n_got - 1] == 8'h3F, "R8 partial zero tail", got_w[n_got - 1], 8'h3F);
        send_px(1'b0, 16'h0800);
        line_break();
        compare("R8 new line at wire 0");
        check(got_w[n_got - 1] == 8'h01, "R8 wire 0 restart", got_w[n_got - 1], 8'h01);

        // R2: top nibble ignored in 4-4-4
        send_px(1'b0, 16'hF777);
        line_break();
        check(got_w[n_got - 1] == 8'h00, "R2 bits 15:12 ignored", got_w[n_got - 1], 0);
        compare("R2 narrow format");

        // R3: dropped bits ignored in 5-6-5, field MSBs used
        send_px(1'b1, 16'h0861);
        send_px(1'b1, 16'h8410);
        line_break();
        check(got_w[n_got - 1] == 8'h38, "R3 565 fields", got_w[n_got - 1], 8'h38);
        compare("R3 wide format");

        // R4: threshold at half scale per channel
        send_px(1'b0, 16'h0789);
        line_break();
        check(got_w[n_got - 1] == 8'h06, "R4 lane threshold", got_w[n_got - 1], 8'h06);
        compare("R4 lanes");

        // R7: data offered without px_valid is not taken
        @(negedge clk);
        fmt_565 = 1'b0; px_data = 16'h0888; px_valid = 1'b0;
        repeat (6) @(negedge clk);
        line_break();
        check(n_got == base_got, "R7 no take without valid", n_got - base_got, 0);
        compare("R7 idle");

        finish_run();
    end

endmodule